// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block sits between a synchronous DRAM command decoder and the column path. It holds the burst configuration, which a mode-set command loads: burst length, burst ordering, read latency and a write option that turns every write into a single column. When a read or write command arrives, the block latches the starting column, the bank bits and the auto-precharge bit. It then drives one column address per clock until the programmed length is used up.

The next burst can start on any clock, including the cycle after the last column of the current burst. A stop command ends a burst early, and a new column command replaces the running burst at once. Each read column raises a read-data-valid pulse exactly the programmed latency later. Columns of a read that was stopped or replaced still produce their pulses.

A three-state controller drives the sequencing:
- `ST_IDLE`: no burst is running.
- `ST_READ`: a read burst is running.
- `ST_WRITE`: a write burst is running.

Its transitions are:
- start-read and start-write, out of any state, when a read or write command arrives.
- burst-done, back to `ST_IDLE` after the last column.
- stop, back to `ST_IDLE` on a stop command.
- hold, in all other cases.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, `burst_active` and `rd_valid` are 0. The configuration is burst length 1, sequential order, latency 2, and writes that burst.
- R2: A command with `cmd_valid`=1 and `cmd_op`=1 (mode set) loads the configuration from `addr`, but only while no burst is running. The fields are:
  - `addr[2:0]`: length code, where 0/1/2/3 select 1/2/4/8 and 7 selects full page.
  - `addr[3]`: order, 0 for sequential and 1 for interleaved.
  - `addr[6:4]`: latency, 2 or 3.
  - `addr[9]`: single write, when 1.
- R3: Some mode-set commands leave the whole configuration unchanged and do not disturb a running burst. These are commands with length code 4, 5 or 6; with length code 7 and interleaved order; with a latency code other than 2 or 3; or issued while a burst is running.
- R4: A read (`cmd_op`=2) or write (`cmd_op`=3) command starts a burst. On the following cycle `burst_active`=1, `col_addr`=`addr[8:0]`, `col_bank`=`bank` and `col_autopre`=`addr[10]`.
- R5: In sequential order with length L, column n of the burst is `(start & ~(L-1)) | ((start+n) & (L-1))`, so the burst wraps inside its aligned block.
- R6: In interleaved order, column n is `start ^ n`.
- R7: A burst of length L presents exactly L columns on consecutive cycles. With no new command, `burst_active` is 0 on the next cycle.
- R8: A full-page burst presents `(start+n) mod 512` and runs past 512 columns until a stop or a new column command arrives.
- R9: With single write set, a write presents one column. Reads keep the programmed length.
- R10: A stop command (`cmd_op`=4) makes `burst_active` 0 on the next cycle.
- R11: A read or write command during a burst replaces it on the next cycle, with new start, type and count. Commands may arrive on every clock.
- R12: `rd_valid` is 1 exactly latency cycles after each cycle that presents a read column, and at no other time. Write columns never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Decoded command strobe |
| cmd_op | input | 3 | 0 none, 1 mode set, 2 read, 3 write, 4 stop |
| addr | input | 12 | Address bus: column, auto-precharge bit, mode fields |
| bank | input | 2 | Bank bits of the column command |
| col_addr | output | 9 | Current burst column |
| col_bank | output | 2 | Bank of the current burst |
| col_autopre | output | 1 | Auto-precharge request of the current burst |
| burst_active | output | 1 | A burst column is presented this cycle |
| rd_valid | output | 1 | Read data expected this cycle |

## Verification
The bench uses the default parameters: a 9-bit column and a latency pipe three deep. With these values every length code, both orders, both latencies and the single-write option can be swept against a range of start columns, including starts near the top of the column space. A full-page burst can be driven past its 512-column wrap in a few hundred cycles. The shallow latency pipe lets the bench model pending read pulses with three history bits. This keeps stops, replacements and back-to-back column commands checkable cycle by cycle.

// File: rtl/bcs_pkg.sv
`timescale 1ns/1ps
package bcs_pkg;
    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_MODE  = 3'd1,
        OP_READ  = 3'd2,
        OP_WRITE = 3'd3,
        OP_STOP  = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } st_e;

    typedef struct packed {
        logic       wr_single;
        logic [1:0] lat;
        logic       ilv;
        logic [2:0] len_code;
    } mode_t;

    localparam logic [2:0] LEN_FULL = 3'd7;
endpackage

// File: rtl/bcs_mode_reg.sv
`timescale 1ns/1ps
module bcs_mode_reg
    import bcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [2:0] len_in,
    input  logic       ilv_in,
    input  logic [2:0] lat_in,
    input  logic       ws_in,
    output mode_t      mode
);
    logic len_ok;
    logic lat_ok;

    always_comb begin
        len_ok = (len_in <= 3'd3) || ((len_in == LEN_FULL) && !ilv_in);
        lat_ok = (lat_in == 3'd2) || (lat_in == 3'd3);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= '{wr_single: 1'b0, lat: 2'd2, ilv: 1'b0, len_code: 3'd0};
        end else if (load && len_ok && lat_ok) begin
            mode <= '{wr_single: ws_in, lat: lat_in[1:0], ilv: ilv_in, len_code: len_in};
        end
    end
endmodule

// File: rtl/bcs_col_gen.sv
`timescale 1ns/1ps
module bcs_col_gen
    import bcs_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] start,
    input  logic [COL_W-1:0] step,
    input  logic [2:0]       len_code,
    input  logic             ilv,
    input  logic             wr_single,
    input  logic             is_wr,
    output logic [COL_W-1:0] col,
    output logic             last
);
    localparam logic [COL_W-1:0] ALL_ONES = '1;

    logic             single;
    logic             full;
    logic [COL_W-1:0] mask;

    always_comb begin
        single = is_wr && wr_single;
        full   = !single && (len_code == LEN_FULL);
        if (single)    mask = '0;
        else if (full) mask = ALL_ONES;
        else           mask = ~(ALL_ONES << len_code[1:0]);
        last = !full && (step == mask);
        if (ilv) col = start ^ (step & mask);
        else     col = (start & ~mask) | ((start + step) & mask);
    end
endmodule

// File: rtl/bcs_rd_pipe.sv
`timescale 1ns/1ps
module bcs_rd_pipe #(
    parameter int MAX_LAT = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       issue,
    input  logic [1:0] lat,
    output logic       rd_valid
);
    logic [MAX_LAT-1:0] stage;

    always_ff @(posedge clk) begin
        if (!rst_n) stage <= '0;
        else        stage <= {stage[MAX_LAT-2:0], issue};
    end

    always_comb begin
        if (lat != 2'd0 && int'(lat) <= MAX_LAT) rd_valid = stage[lat - 2'd1];
        else                                      rd_valid = 1'b0;
    end
endmodule

// File: rtl/burst_col_seq.sv
`timescale 1ns/1ps
module burst_col_seq
    import bcs_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int COL_W   = 9,
    parameter int BANK_W  = 2,
    parameter int AP_BIT  = 10,
    parameter int WS_BIT  = 9,
    parameter int MAX_LAT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BANK_W-1:0] bank,
    output logic [COL_W-1:0]  col_addr,
    output logic [BANK_W-1:0] col_bank,
    output logic              col_autopre,
    output logic              burst_active,
    output logic              rd_valid
);
    st_e               state;
    st_e               state_nx;
    mode_t             mode;
    logic [COL_W-1:0]  start_q;
    logic [COL_W-1:0]  step_q;
    logic [BANK_W-1:0] bank_q;
    logic              ap_q;
    logic              last;
    logic              is_rd;
    logic              is_wr;
    logic              is_stop;
    logic              mode_load;
    logic              unused_row;

    assign unused_row = ^addr[ADDR_W-1:AP_BIT+1];

    always_comb begin
        is_rd     = cmd_valid && (op_e'(cmd_op) == OP_READ);
        is_wr     = cmd_valid && (op_e'(cmd_op) == OP_WRITE);
        is_stop   = cmd_valid && (op_e'(cmd_op) == OP_STOP);
        mode_load = cmd_valid && (op_e'(cmd_op) == OP_MODE) && (state == ST_IDLE);
    end

    bcs_mode_reg u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (mode_load),
        .len_in (addr[2:0]),
        .ilv_in (addr[3]),
        .lat_in (addr[6:4]),
        .ws_in  (addr[WS_BIT]),
        .mode   (mode)
    );

    bcs_col_gen #(.COL_W(COL_W)) u_gen (
        .start     (start_q),
        .step      (step_q),
        .len_code  (mode.len_code),
        .ilv       (mode.ilv),
        .wr_single (mode.wr_single),
        .is_wr     (state == ST_WRITE),
        .col       (col_addr),
        .last      (last)
    );

    bcs_rd_pipe #(.MAX_LAT(MAX_LAT)) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue    (state == ST_READ),
        .lat      (mode.lat),
        .rd_valid (rd_valid)
    );

    // transitions: start-read, start-write, stop, burst-done, hold
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (is_rd)      state_nx = ST_READ;
                else if (is_wr) state_nx = ST_WRITE;
            end
            ST_READ, ST_WRITE: begin
                if (is_rd)                state_nx = ST_READ;
                else if (is_wr)           state_nx = ST_WRITE;
                else if (is_stop || last) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            step_q  <= '0;
            bank_q  <= '0;
            ap_q    <= 1'b0;
        end else if (is_rd || is_wr) begin
            start_q <= addr[COL_W-1:0];
            step_q  <= '0;
            bank_q  <= bank;
            ap_q    <= addr[AP_BIT];
        end else if (state != ST_IDLE && !last) begin
            step_q  <= step_q + 1'b1;
        end
    end

    always_comb begin
        burst_active = (state != ST_IDLE);
        col_bank     = bank_q;
        col_autopre  = ap_q;
    end
endmodule

// File: rtl/bcs_chk.sv
`timescale 1ns/1ps
module bcs_chk
    import bcs_pkg::*;
#(
    parameter int COL_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [2:0]       cmd_op,
    input logic [COL_W-1:0] cmd_col,
    input logic [COL_W-1:0] col_addr,
    input logic             burst_active,
    input logic             rd_valid,
    input st_e              state,
    input mode_t            mode,
    input logic             last
);
    logic [1:0] since;
    logic       col_cmd;

    always_ff @(posedge clk) begin
        if (!rst_n)              since <= 2'd0;
        else if (since != 2'd3)  since <= since + 2'd1;
    end

    assign col_cmd = cmd_valid && (cmd_op == 3'd2 || cmd_op == 3'd3);

    // R4
    start_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        col_cmd |=> (burst_active && col_addr == $past(cmd_col)));

    // R10
    stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd4) |=> !burst_active);

    // R7
    burst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_active && last && !col_cmd) |=> !burst_active);

    // R3
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd1 && burst_active) |=> $stable(mode));

    // R12
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since == 2'd3) |-> (rd_valid == ((mode.lat == 2'd3) ?
            $past(state == ST_READ, 3) : $past(state == ST_READ, 2))));
endmodule

bind burst_col_seq bcs_chk #(.COL_W(COL_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_op       (cmd_op),
    .cmd_col      (addr[COL_W-1:0]),
    .col_addr     (col_addr),
    .burst_active (burst_active),
    .rd_valid     (rd_valid),
    .state        (state),
    .mode         (mode),
    .last         (last)
);

// File: tb/sim_burst_col_seq.sv
`timescale 1ns/1ps
module sim_burst_col_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [11:0] addr = '0;
    logic [1:0]  bank = '0;
    logic [8:0]  col_addr;
    logic [1:0]  col_bank;
    logic        col_autopre;
    logic        burst_active;
    logic        rd_valid;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // bench model of the configuration
    int m_lg = 0;
    bit m_full = 0;
    bit m_ilv = 0;
    int m_cl = 2;
    bit m_ws = 0;
    bit hist[1:3] = '{0, 0, 0};

    always #2 clk = ~clk;

    burst_col_seq u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .addr(addr), .bank(bank), .col_addr(col_addr), .col_bank(col_bank),
        .col_autopre(col_autopre), .burst_active(burst_active), .rd_valid(rd_valid)
    );

    task automatic chk(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_col(int s, int n, bit single);
        int mask;
        if (single)      mask = 0;
        else if (m_full) mask = 511;
        else             mask = (1 << m_lg) - 1;
        if (m_ilv) return (s ^ (n & mask)) & 511;
        return ((s & ~mask) | ((s + n) & mask)) & 511;
    endfunction

    // drive one cycle's command, then check the outputs at the next falling edge
    task automatic cyc(bit cv, int op, int a, int b, bit e_act, int e_col, bit e_rd, string req);
        cmd_valid = cv;
        cmd_op    = 3'(op);
        addr      = 12'(a);
        bank      = 2'(b);
        @(negedge clk);
        chk(burst_active == e_act, "R7 burst_active", int'(burst_active), int'(e_act));
        if (e_act) chk(int'(col_addr) == e_col, req, int'(col_addr), e_col);
        chk(rd_valid == hist[m_cl], "R12 rd_valid", int'(rd_valid), int'(hist[m_cl]));
        hist[3] = hist[2];
        hist[2] = hist[1];
        hist[1] = e_act && e_rd;
    endtask

    task automatic drain();
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 0, 0, "R7");
    endtask

    task automatic set_mode(int blc, bit ilv, int clc, bit ws);
        bit accept;
        accept = (blc <= 3 || (blc == 7 && !ilv)) && (clc == 2 || clc == 3);
        cyc(1, 1, (int'(ws) << 9) | (clc << 4) | (int'(ilv) << 3) | blc, 0, 0, 0, 0, "R2");
        if (accept) begin
            m_full = (blc == 7);
            m_lg   = blc & 3;
            m_ilv  = ilv;
            m_cl   = clc;
            m_ws   = ws;
        end
    endtask

    task automatic run_burst(bit rd, int s, int b, bit ap);
        bit single;
        int n_cols;
        string req;
        single = !rd && m_ws;
        n_cols = single ? 1 : (1 << m_lg);
        req = single ? "R9 col" : (m_ilv ? "R6 col" : "R5 col");
        cyc(1, rd ? 2 : 3, s | (int'(ap) << 10), b, 1, exp_col(s, 0, single), rd, req);
        chk(int'(col_bank) == b, "R4 bank", int'(col_bank), b);
        chk(col_autopre == ap, "R4 autopre", int'(col_autopre), int'(ap));
        for (int n = 1; n < n_cols; n++) cyc(0, 0, 0, 0, 1, exp_col(s, n, single), rd, req);
        drain();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(burst_active == 0, "R1 reset active", int'(burst_active), 0);
        chk(rd_valid == 0, "R1 reset rd_valid", int'(rd_valid), 0);
        rst_n = 1'b1;
        drain();
        // R1: default configuration is length 1, latency 2
        run_burst(1, 5, 2, 1);
        run_burst(0, 6, 1, 0);

        // R2 R5 R6 R9 R12: sweep lengths, orders, latencies
        for (int blc = 0; blc < 4; blc++)
            for (int il = 0; il < 2; il++)
                for (int cl = 2; cl < 4; cl++) begin
                    set_mode(blc, il[0], cl, blc[0]);
                    for (int s = 0; s < 16; s++) begin
                        run_burst(1, s, s % 4, s[0]);
                        run_burst(0, s, s % 4, s[1]);
                    end
                    run_burst(1, 509, 3, 0);
                    run_burst(0, 510, 2, 1);
                end

        // R8: full page wraps and continues until stop (R10)
        set_mode(7, 0, 3, 0);
        cyc(1, 2, 500, 1, 1, 500, 1, "R8 col");
        for (int n = 1; n < 530; n++) cyc(0, 0, 0, 0, 1, (500 + n) % 512, 1, "R8 col");
        cyc(1, 4, 0, 0, 0, 0, 0, "R10 stop");
        drain();

        // R3: reserved codes leave length 4 / latency 3 unchanged
        set_mode(2, 0, 3, 0);
        set_mode(4, 0, 3, 0);
        set_mode(7, 1, 2, 0);
        set_mode(1, 0, 1, 0);
        set_mode(0, 0, 4, 1);
        run_burst(1, 6, 0, 0);
        run_burst(0, 13, 1, 0);
        // R3: mode set during a burst is ignored and does not break it
        cyc(1, 2, 9, 0, 1, 9, 1, "R3 col");
        cyc(1, 1, 12'h020, 0, 1, 10, 1, "R3 col");
        cyc(0, 0, 0, 0, 1, 11, 1, "R3 col");
        cyc(0, 0, 0, 0, 1, 8, 1, "R3 col");
        drain();
        run_burst(1, 2, 0, 0);

        // R10: stop in the middle of a length-8 read
        set_mode(3, 0, 2, 0);
        cyc(1, 2, 0, 0, 1, 0, 1, "R10 col");
        cyc(0, 0, 0, 0, 1, 1, 1, "R10 col");
        cyc(1, 4, 0, 0, 0, 0, 0, "R10 stop");
        drain();

        // R11: write interrupts read; reads back to back every clock
        cyc(1, 2, 3, 0, 1, 3, 1, "R11 col");
        cyc(0, 0, 0, 0, 1, 4, 1, "R11 col");
        cyc(0, 0, 0, 0, 1, 5, 1, "R11 col");
        cyc(1, 3, 20, 1, 1, 20, 0, "R11 col");
        chk(int'(col_bank) == 1, "R11 bank", int'(col_bank), 1);
        for (int n = 1; n < 8; n++) cyc(0, 0, 0, 0, 1, exp_col(20, n, 0), 0, "R11 col");
        drain();
        for (int i = 0; i < 5; i++) cyc(1, 2, 8 * i + 1, 0, 1, 8 * i + 1, 1, "R11 col");
        for (int n = 1; n < 8; n++) cyc(0, 0, 0, 0, 1, exp_col(33, n, 0), 1, "R11 col");
        drain();

        // R11 with interleave, latency 3: read replaced by a single-write
        set_mode(3, 1, 3, 1);
        cyc(1, 2, 5, 0, 1, 5, 1, "R11 col");
        cyc(1, 3, 7, 0, 1, 7, 0, "R11 col");
        cyc(1, 2, 2, 0, 1, 2, 1, "R11 col");
        for (int n = 1; n < 8; n++) cyc(0, 0, 0, 0, 1, 2 ^ n, 1, "R11 col");
        drain();

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule